// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative cache of page translations. A requester presents a virtual address together with the address-space ID of the running task. One cycle later the block reports either a hit, with the physical address and the read/write/execute permission bits, or a miss. The low 12 bits of the address are the offset within a 4 KB page and pass through unchanged. The upper 20 bits form the virtual page number that is searched for.

On a miss, an external agent finds the mapping and writes it through the fill port. The requester then retries the lookup. Each stored translation carries an address-space tag and a global flag. A non-global entry serves only lookups with the same ID. A global entry serves every ID. The running ID can change freely and this invalidates nothing. The flush port either clears the whole table, or clears only the non-global entries, which is the cheap path for a task switch.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup hits when a valid entry holds the requested virtual page number, `vaddr[31:12]`, and that entry's context rule (R5, R6) allows the match. The result is the physical page number stored in that entry.
- R2: On a hit, `lk_paddr_o` is `{ppn, vaddr[11:0]}` and `lk_prot_o` is the stored bits in the order {read, write, execute}, MSB first. On a miss, or in any cycle without a response, both outputs are zero.
- R3: `lk_valid_o` is high in exactly the cycle after a cycle with `lk_req_i` high. In that cycle exactly one of `lk_hit_o` and `lk_miss_o` is high. In every other cycle, including reset, all three are low.
- R4: A lookup that no entry serves raises `lk_miss_o`. After a fill of that page and ID, a retried lookup hits.
- R5: A non-global entry serves a lookup only when its stored ID equals `cur_asid_i`.
- R6: A global entry serves a lookup whatever the value of `cur_asid_i`.
- R7: A flush with `flush_keep_glob_i`=1 invalidates every non-global entry and leaves global entries valid.
- R8: A flush with `flush_keep_glob_i`=0 invalidates every entry, global ones included.
- R9: Changing `cur_asid_i` invalidates no entry. A return to an earlier ID hits on its earlier translations.
- R10: A fill that overlaps no valid entry goes to the lowest-index invalid entry. If all 16 entries are valid, it goes to the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping at 15, only on such a replacement.
- R11: A fill overlaps a valid entry when the virtual page numbers match and, in addition, the IDs are equal or either the entry or the fill is global. The fill is written into the lowest-index overlapping entry. Every other overlapping entry is invalidated.
- R12: A lookup in the same cycle as a fill or a flush sees the table as it was before that update.
- R13: When a flush and a fill are requested in the same cycle, only the flush takes effect and the fill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_req_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| cur_asid_i | input | 8 | Address-space ID of the running task |
| lk_valid_o | output | 1 | Response valid, one cycle after the request |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | No translation found |
| lk_paddr_o | output | 32 | Physical address (zero on a miss) |
| lk_prot_o | output | 3 | Permission bits {read, write, execute} |
| fill_req_i | input | 1 | Write a translation |
| fill_vpn_i | input | 20 | Virtual page number to write |
| fill_asid_i | input | 8 | Address-space ID to write |
| fill_glob_i | input | 1 | Global flag to write |
| fill_ppn_i | input | 20 | Physical page number to write |
| fill_prot_i | input | 3 | Permission bits to write |
| flush_req_i | input | 1 | Flush request |
| flush_keep_glob_i | input | 1 | 1: keep global entries (task-switch flush); 0: flush everything |

## Verification
Directed sequences cover four distinct cases:
- a miss-fill-retry sequence;
- lookups of one page under its own ID, a foreign ID and, after a detour, its own ID again, which separate tag matching from invalidation;
- global pages looked up under unrelated IDs and across both flush kinds;
- same-cycle fill-with-lookup and flush-with-fill, which expose update ordering.

Filling 18 distinct pages shows whether placement takes free slots first and then evicts in round-robin order. A triple fill of one page under two IDs and then as global shows whether overlapping copies are merged. A long random phase runs over a tiny page and ID space, so that overlaps, evictions and flushes collide densely. It is compared each cycle against a behavioural table model.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
  parameter int unsigned VA_W     = 32;
  parameter int unsigned PG_OFF_W = 12;
  parameter int unsigned PPN_W    = 20;
  parameter int unsigned ASID_W   = 8;
  parameter int unsigned PROT_W   = 3;
  localparam int unsigned VPN_W   = VA_W - PG_OFF_W;
  localparam int unsigned PA_W    = PPN_W + PG_OFF_W;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PPN_W-1:0]  ppn;
    logic [PROT_W-1:0] prot;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match
  import tlb_xlate_pkg::*;
#(
  parameter  int unsigned N     = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      valid_i,
  input  tlb_entry_t        ents_i [N],
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              any_ctx_i,  // key side treats every ID as matching
  output logic [N-1:0]      hit_vec_o,
  output logic [IDX_W-1:0]  idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (ents_i[g].vpn == vpn_i) &&
                          (ents_i[g].glob || any_ctx_i || (ents_i[g].asid == asid_i));
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter  int unsigned N     = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             do_fill_i,
  input  logic [N-1:0]     valid_i,
  input  logic             ovl_any_i,
  input  logic [IDX_W-1:0] ovl_idx_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             full;
  logic             use_rr;

  assign full = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign use_rr = !ovl_any_i && full;
  assign idx_o  = ovl_any_i ? ovl_idx_i : (full ? rr_q : free_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (do_fill_i && use_rr) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_RR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(do_fill_i && !ovl_any_i && full) |=> $stable(rr_q)); // R10
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_xlate_pkg::*;
#(
  parameter  int unsigned N     = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  tlb_entry_t       wr_ent_i,
  input  logic [N-1:0]     kill_i,
  input  logic             flush_i,
  input  logic             keep_glob_i,
  output logic [N-1:0]     valid_o,
  output tlb_entry_t       ents_o [N]
);
  logic [N-1:0] valid_q;
  logic [N-1:0] glob_vec;
  logic         do_wr;

  assign do_wr = wr_en_i && !flush_i;  // flush wins

  for (genvar g = 0; g < N; g++) begin : g_glob
    assign glob_vec[g] = ents_o[g].glob;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= keep_glob_i ? (valid_q & glob_vec) : '0;
    end else if (do_wr) begin
      valid_q <= (valid_q & ~kill_i) | (N'(1) << wr_idx_i);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_data
    always_ff @(posedge clk_i) begin
      if (do_wr && (wr_idx_i == IDX_W'(g))) ents_o[g] <= wr_ent_i;
    end
  end

  assign valid_o = valid_q;

  AST_FULL_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !keep_glob_i) |=> (valid_q == '0)); // R8
  AST_CTX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && keep_glob_i) |=> ((valid_q & ~glob_vec) == '0)); // R7
  AST_FLUSH_NO_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ((valid_q & ~$past(valid_q)) == '0)); // R13
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter  int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic              lk_valid_o,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  output logic [PROT_W-1:0] lk_prot_o,
  input  logic              fill_req_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_glob_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [PROT_W-1:0] fill_prot_i,
  input  logic              flush_req_i,
  input  logic              flush_keep_glob_i
);
  logic [N_ENTRIES-1:0] valid;
  tlb_entry_t           ents [N_ENTRIES];
  logic [N_ENTRIES-1:0] lk_vec, ovl_vec;
  logic [IDX_W-1:0]     lk_idx, ovl_idx, wr_idx;
  logic                 lk_any;
  tlb_entry_t           wr_ent;

  tlb_cam_match #(.N(N_ENTRIES)) u_lk_match (
    .valid_i   (valid),
    .ents_i    (ents),
    .vpn_i     (lk_vaddr_i[VA_W-1:PG_OFF_W]),
    .asid_i    (cur_asid_i),
    .any_ctx_i (1'b0),
    .hit_vec_o (lk_vec),
    .idx_o     (lk_idx)
  );

  tlb_cam_match #(.N(N_ENTRIES)) u_ovl_match (
    .valid_i   (valid),
    .ents_i    (ents),
    .vpn_i     (fill_vpn_i),
    .asid_i    (fill_asid_i),
    .any_ctx_i (fill_glob_i),
    .hit_vec_o (ovl_vec),
    .idx_o     (ovl_idx)
  );

  tlb_victim #(.N(N_ENTRIES)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .do_fill_i (fill_req_i && !flush_req_i),
    .valid_i   (valid),
    .ovl_any_i (|ovl_vec),
    .ovl_idx_i (ovl_idx),
    .idx_o     (wr_idx)
  );

  assign wr_ent = '{vpn: fill_vpn_i, asid: fill_asid_i, glob: fill_glob_i,
                    ppn: fill_ppn_i, prot: fill_prot_i};

  tlb_store #(.N(N_ENTRIES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (fill_req_i),
    .wr_idx_i    (wr_idx),
    .wr_ent_i    (wr_ent),
    .kill_i      (ovl_vec),
    .flush_i     (flush_req_i),
    .keep_glob_i (flush_keep_glob_i),
    .valid_o     (valid),
    .ents_o      (ents)
  );

  assign lk_any = |lk_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_miss_o  <= 1'b0;
      lk_paddr_o <= '0;
      lk_prot_o  <= '0;
    end else begin
      lk_valid_o <= lk_req_i;
      lk_hit_o   <= lk_req_i && lk_any;
      lk_miss_o  <= lk_req_i && !lk_any;
      lk_paddr_o <= (lk_req_i && lk_any) ?
                    {ents[lk_idx].ppn, lk_vaddr_i[PG_OFF_W-1:0]} : '0;
      lk_prot_o  <= (lk_req_i && lk_any) ? ents[lk_idx].prot : '0;
    end
  end

  AST_REQ_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> (lk_valid_o && (lk_hit_o != lk_miss_o))); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_o |-> (!lk_hit_o && !lk_miss_o)); // R3
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_paddr_o == '0 && lk_prot_o == '0)); // R2
  AST_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec)); // R11
endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  cur_asid = '0;
  logic        lk_valid, lk_hit, lk_miss;
  logic [31:0] lk_pa;
  logic [2:0]  lk_prot;
  logic        f_req = 1'b0;
  logic [19:0] f_vpn = '0;
  logic [7:0]  f_asid = '0;
  logic        f_glob = 1'b0;
  logic [19:0] f_ppn = '0;
  logic [2:0]  f_prot = '0;
  logic        fl_req = 1'b0;
  logic        fl_keep = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural table model
  bit          m_v    [NE];
  int unsigned m_vpn  [NE];
  int unsigned m_asid [NE];
  bit          m_g    [NE];
  int unsigned m_ppn  [NE];
  int unsigned m_prot [NE];
  int          m_rr;

  always #2 clk = ~clk;

  tlb_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_req_i(lk_req), .lk_vaddr_i(lk_va), .cur_asid_i(cur_asid),
    .lk_valid_o(lk_valid), .lk_hit_o(lk_hit), .lk_miss_o(lk_miss),
    .lk_paddr_o(lk_pa), .lk_prot_o(lk_prot),
    .fill_req_i(f_req), .fill_vpn_i(f_vpn), .fill_asid_i(f_asid),
    .fill_glob_i(f_glob), .fill_ppn_i(f_ppn), .fill_prot_i(f_prot),
    .flush_req_i(fl_req), .flush_keep_glob_i(fl_keep)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not end (act=hung exp=done)");
    summary();
  end

  task automatic compare(string tag, bit ev, bit eh, bit em, logic [31:0] ep, logic [2:0] epr);
    n_cmp++;
    if (lk_valid !== ev || lk_hit !== eh || lk_miss !== em || lk_pa !== ep || lk_prot !== epr) begin
      n_bad++;
      $display("FAIL %s: act v=%b h=%b m=%b pa=%h pr=%h exp v=%b h=%b m=%b pa=%h pr=%h",
               tag, lk_valid, lk_hit, lk_miss, lk_pa, lk_prot, ev, eh, em, ep, epr);
    end
  endtask

  // one cycle: expected result from pre-edge model, then model update
  task automatic tick(string tag);
    bit eh = 0;
    logic [31:0] ep = '0;
    logic [2:0]  epr = '0;
    if (lk_req) begin
      for (int i = 0; i < NE; i++) begin
        if (!eh && m_v[i] && m_vpn[i] == lk_va[31:12] && (m_g[i] || m_asid[i] == cur_asid)) begin
          eh = 1;
          ep = {m_ppn[i][19:0], lk_va[11:0]};
          epr = m_prot[i][2:0];
        end
      end
    end
    if (fl_req) begin
      for (int i = 0; i < NE; i++) if (!(fl_keep && m_g[i])) m_v[i] = 0;
    end else if (f_req) begin
      int tgt = -1;
      for (int i = 0; i < NE; i++) begin
        if (m_v[i] && m_vpn[i] == f_vpn && (m_g[i] || f_glob || m_asid[i] == f_asid)) begin
          if (tgt < 0) tgt = i; else m_v[i] = 0;
        end
      end
      if (tgt < 0) for (int i = 0; i < NE; i++) if (tgt < 0 && !m_v[i]) tgt = i;
      if (tgt < 0) begin tgt = m_rr; m_rr = (m_rr + 1) % NE; end
      m_v[tgt] = 1; m_vpn[tgt] = f_vpn; m_asid[tgt] = f_asid; m_g[tgt] = f_glob;
      m_ppn[tgt] = f_ppn; m_prot[tgt] = f_prot;
    end
    @(posedge clk); #1;
    compare(tag, lk_req, lk_req && eh, lk_req && !eh, ep, epr);
    lk_req = 0; f_req = 0; fl_req = 0;
    @(negedge clk);
  endtask

  task automatic look(string tag, logic [31:0] va, logic [7:0] id);
    lk_req = 1; lk_va = va; cur_asid = id; tick(tag);
  endtask

  task automatic set_fill(logic [19:0] vpn, logic [7:0] id, bit g, logic [19:0] ppn, logic [2:0] pr);
    f_req = 1; f_vpn = vpn; f_asid = id; f_glob = g; f_ppn = ppn; f_prot = pr;
  endtask

  initial begin
    for (int i = 0; i < NE; i++) m_v[i] = 0;
    m_rr = 0;
    #1;
    repeat (3) @(negedge clk);
    compare("R3 reset", 0, 0, 0, '0, '0);
    rst_n = 1;
    @(negedge clk);
    tick("R3 idle");

    look("R4 cold miss", 32'h12345ABC, 8'd1);
    set_fill(20'h12345, 8'd1, 0, 20'hABCDE, 3'b101); tick("R10 fill");
    look("R1 R2 R4 retry hit", 32'h12345ABC, 8'd1);
    tick("R3 idle");
    look("R5 foreign id", 32'h12345ABC, 8'd2);
    look("R9 id back", 32'h12345123, 8'd1);

    set_fill(20'h00077, 8'd3, 1, 20'h11111, 3'b001); tick("R6 fill global");
    look("R6 global any id", 32'h00077FFF, 8'd9);

    set_fill(20'h22222, 8'd1, 0, 20'h33333, 3'b110);
    lk_req = 1; lk_va = 32'h22222000; cur_asid = 8'd1; tick("R12 same-cycle fill");
    look("R12 after fill", 32'h22222000, 8'd1);

    fl_req = 1; fl_keep = 1; lk_req = 1; lk_va = 32'h12345000; cur_asid = 8'd1;
    tick("R12 same-cycle flush");
    look("R7 ctx flush drops", 32'h12345000, 8'd1);
    look("R7 ctx flush keeps global", 32'h00077000, 8'd4);

    set_fill(20'h33333, 8'd1, 0, 20'h44444, 3'b111); fl_req = 1; fl_keep = 0; tick("R13 flush+fill");
    look("R13 fill dropped", 32'h33333000, 8'd1);
    look("R8 global flushed", 32'h00077000, 8'd4);

    set_fill(20'h00040, 8'd1, 0, 20'h0000A, 3'b100); tick("R11 fill a");
    set_fill(20'h00040, 8'd2, 0, 20'h0000B, 3'b010); tick("R11 fill b");
    look("R11 own copy a", 32'h00040000, 8'd1);
    set_fill(20'h00040, 8'd5, 1, 20'h0000C, 3'b001); tick("R11 fill global merges");
    look("R11 merged id1", 32'h00040000, 8'd1);
    look("R11 merged id2", 32'h00040000, 8'd2);

    fl_req = 1; fl_keep = 0; tick("R8 flush");
    for (int k = 0; k < 18; k++) begin
      set_fill(20'h50000 + 20'(k), 8'd7, 0, 20'h60000 + 20'(k), 3'(k)); tick("R10 fill seq");
    end
    look("R10 rr evict 0", 32'h50000000, 8'd7);
    look("R10 rr evict 1", 32'h50001000, 8'd7);
    look("R10 survivor", 32'h50002000, 8'd7);
    look("R10 newest", 32'h50011000, 8'd7);

    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      lk_req = ($urandom_range(0, 3) != 0);
      lk_va = {17'h0, 3'($urandom_range(0, 7)), 12'($urandom)};
      cur_asid = 8'($urandom_range(0, 3));
      if (r < 40) set_fill(20'($urandom_range(0, 7)), 8'($urandom_range(0, 3)),
                           ($urandom_range(0, 4) == 0), 20'($urandom), 3'($urandom));
      if (r >= 97 || (r < 2)) begin fl_req = 1; fl_keep = 1'($urandom); end
      tick("R1 random");
    end
    summary();
  end
endmodule